// File: doc/BRIEF.md
# Dual-Channel Registered Bus Transceiver

This block moves bytes between two ports, called A and B, on several independent channels (two by default, one byte wide each). On every channel a direction input picks which port is driven, an active-low enable can disconnect both ports, and a pair of select inputs decides, for each direction, whether the driven port carries the live value presented at the opposite port or a byte held in a storage register. Each channel owns two storage registers: one samples port A on the rising edge of its own capture clock, the other samples port B on the rising edge of a second capture clock. Sampling never depends on the enable or the direction, so a channel can record traffic while it is disconnected and replay it later.

Pins that would be bidirectional on a board are split into an input bus, an output bus and a per-channel drive-enable for each port. The live path and the drive-enables are combinational. A port that is not driven shows zero on its output bus. A synchronous active-high reset clears each storage register on the next rising edge of that register's own capture clock.

Top module: `bus_xcvr_top`

## Requirements
- R1: On each rising edge of `cap_a_clk[i]` the A-held register of channel i loads `a_in` of that channel, whatever `en_n`, `dir` and the selects are; it is observed on `b_out` with `en_n=0`, `dir=1`, `sel_b_src=1`.
- R2: On each rising edge of `cap_b_clk[i]` the B-held register of channel i loads `b_in` of that channel, whatever `en_n`, `dir` and the selects are; it is observed on `a_out` with `en_n=0`, `dir=0`, `sel_a_src=1`.
- R3: With `en_n[i]=1` the channel drives neither port: `a_drv[i]=0`, `b_drv[i]=0`, and both output bytes of the channel read 0.
- R4: With `en_n[i]=0` and `dir[i]=0` the channel drives port A (`a_drv[i]=1`), does not drive port B (`b_drv[i]=0`), and its `b_out` byte reads 0.
- R5: With `en_n[i]=0` and `dir[i]=1` the channel drives port B (`b_drv[i]=1`), does not drive port A (`a_drv[i]=0`), and its `a_out` byte reads 0.
- R6: While port A is driven, `sel_a_src[i]=0` puts the live `b_in` byte on `a_out` in the same cycle and `sel_a_src[i]=1` puts the B-held register there.
- R7: While port B is driven, `sel_b_src[i]=0` puts the live `a_in` byte on `b_out` in the same cycle and `sel_b_src[i]=1` puts the A-held register there.
- R8: `a_drv[i]` and `b_drv[i]` are never both 1.
- R9: Channels are independent: inputs and clock edges of one channel never change the outputs or held registers of another.
- R10: With `rst=1` at a rising edge of a capture clock, the register owned by that clock becomes 0; the other register of the channel keeps its value until its own clock rises.
- R11: A held register keeps its value between rising edges of its own clock, regardless of changes on the data buses or on the other capture clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled by every capture clock |
| cap_a_clk | input | NUM_LANES | Per channel, rising edge loads the A-held register from `a_in` |
| cap_b_clk | input | NUM_LANES | Per channel, rising edge loads the B-held register from `b_in` |
| en_n | input | NUM_LANES | Per channel active-low output enable |
| dir | input | NUM_LANES | Per channel direction: 0 drives port A, 1 drives port B |
| sel_a_src | input | NUM_LANES | Source for port A: 0 live `b_in`, 1 B-held register |
| sel_b_src | input | NUM_LANES | Source for port B: 0 live `a_in`, 1 A-held register |
| a_in | input | LANE_W*NUM_LANES | Value seen on port A; channel i in bits [i*LANE_W +: LANE_W] |
| b_in | input | LANE_W*NUM_LANES | Value seen on port B; same channel packing |
| a_out | output | LANE_W*NUM_LANES | Value driven onto port A, zero when not driven |
| b_out | output | LANE_W*NUM_LANES | Value driven onto port B, zero when not driven |
| a_drv | output | NUM_LANES | Per channel drive-enable for port A |
| b_drv | output | NUM_LANES | Per channel drive-enable for port B |

## Verification
The bench captures bytes while the channel is disabled or pointed the other way, then changes the buses and turns the channel on: a design that gated capture with the enable or direction would replay the old or the reset value. It pulses only one capture clock while reset is high and checks that the other register survives, which catches a reset wired to the wrong clock or applied asynchronously to both. It toggles one channel while the other replays stored data, exposing crossed bit slices or shared clocks, and it watches both drive-enables in every mode so that a decode that let both ports drive, or left stale data on the undriven bus, shows up at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        RT_ISOLATE = 2'd0,
        RT_TO_A    = 2'd1,
        RT_TO_B    = 2'd2
    } route_e;

    function automatic route_e route_of(input logic en_n, input logic dir);
        if (en_n)
            return RT_ISOLATE;
        else if (dir)
            return RT_TO_B;
        else
            return RT_TO_A;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] held
);
    typedef struct packed {
        logic [W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst)
            st_d.data = '0;
        else
            st_d.data = d_in;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign held = st_q.data;
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         en_n,
    input  logic         dir,
    input  logic         sel_a_src,
    input  logic         sel_b_src,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] hold_a,
    input  logic [W-1:0] hold_b,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_drv,
    output logic         b_drv
);
    route_e mode;

    always_comb begin
        mode  = route_of(en_n, dir);
        a_drv = 1'b0;
        b_drv = 1'b0;
        a_out = '0;
        b_out = '0;
        unique case (mode)
            RT_TO_A: begin
                a_drv = 1'b1;
                a_out = sel_a_src ? hold_b : b_in;
            end
            RT_TO_B: begin
                b_drv = 1'b1;
                b_out = sel_b_src ? hold_a : a_in;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int W = 8
) (
    input  logic         rst,
    input  logic         cap_a_clk,
    input  logic         cap_b_clk,
    input  logic         en_n,
    input  logic         dir,
    input  logic         sel_a_src,
    input  logic         sel_b_src,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_drv,
    output logic         b_drv,
    output logic [W-1:0] hold_a,
    output logic [W-1:0] hold_b
);
    xcvr_store #(.W(W)) u_hold_a (
        .clk  (cap_a_clk),
        .rst  (rst),
        .d_in (a_in),
        .held (hold_a)
    );

    xcvr_store #(.W(W)) u_hold_b (
        .clk  (cap_b_clk),
        .rst  (rst),
        .d_in (b_in),
        .held (hold_b)
    );

    xcvr_route #(.W(W)) u_route (
        .en_n      (en_n),
        .dir       (dir),
        .sel_a_src (sel_a_src),
        .sel_b_src (sel_b_src),
        .a_in      (a_in),
        .b_in      (b_in),
        .hold_a    (hold_a),
        .hold_b    (hold_b),
        .a_out     (a_out),
        .b_out     (b_out),
        .a_drv     (a_drv),
        .b_drv     (b_drv)
    );
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 2
) (
    input  logic                          rst,
    input  logic [NUM_LANES-1:0]          cap_a_clk,
    input  logic [NUM_LANES-1:0]          cap_b_clk,
    input  logic [NUM_LANES-1:0]          en_n,
    input  logic [NUM_LANES-1:0]          dir,
    input  logic [NUM_LANES-1:0]          sel_a_src,
    input  logic [NUM_LANES-1:0]          sel_b_src,
    input  logic [LANE_W*NUM_LANES-1:0]   a_in,
    input  logic [LANE_W*NUM_LANES-1:0]   b_in,
    output logic [LANE_W*NUM_LANES-1:0]   a_out,
    output logic [LANE_W*NUM_LANES-1:0]   b_out,
    output logic [NUM_LANES-1:0]          a_drv,
    output logic [NUM_LANES-1:0]          b_drv
);
    localparam int BUS_W = LANE_W * NUM_LANES;

    logic [BUS_W-1:0] stash_a;
    logic [BUS_W-1:0] stash_b;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        xcvr_lane #(.W(LANE_W)) u_lane (
            .rst       (rst),
            .cap_a_clk (cap_a_clk[g]),
            .cap_b_clk (cap_b_clk[g]),
            .en_n      (en_n[g]),
            .dir       (dir[g]),
            .sel_a_src (sel_a_src[g]),
            .sel_b_src (sel_b_src[g]),
            .a_in      (a_in[g*LANE_W +: LANE_W]),
            .b_in      (b_in[g*LANE_W +: LANE_W]),
            .a_out     (a_out[g*LANE_W +: LANE_W]),
            .b_out     (b_out[g*LANE_W +: LANE_W]),
            .a_drv     (a_drv[g]),
            .b_drv     (b_drv[g]),
            .hold_a    (stash_a[g*LANE_W +: LANE_W]),
            .hold_b    (stash_b[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 2
) (
    input logic                        rst,
    input logic [NUM_LANES-1:0]        cap_a_clk,
    input logic [NUM_LANES-1:0]        cap_b_clk,
    input logic [NUM_LANES-1:0]        en_n,
    input logic [NUM_LANES-1:0]        dir,
    input logic [NUM_LANES-1:0]        sel_a_src,
    input logic [NUM_LANES-1:0]        sel_b_src,
    input logic [LANE_W*NUM_LANES-1:0] a_in,
    input logic [LANE_W*NUM_LANES-1:0] b_in,
    input logic [LANE_W*NUM_LANES-1:0] a_out,
    input logic [LANE_W*NUM_LANES-1:0] b_out,
    input logic [NUM_LANES-1:0]        a_drv,
    input logic [NUM_LANES-1:0]        b_drv,
    input logic [LANE_W*NUM_LANES-1:0] stash_a,
    input logic [LANE_W*NUM_LANES-1:0] stash_b
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
        // R1
        capture_a_chk: assert property (@(posedge cap_a_clk[g]) disable iff (rst)
            !rst |=> stash_a[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W]));

        // R2
        capture_b_chk: assert property (@(posedge cap_b_clk[g]) disable iff (rst)
            !rst |=> stash_b[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W]));

        // R10
        reset_a_chk: assert property (@(posedge cap_a_clk[g])
            rst |=> stash_a[g*LANE_W +: LANE_W] == '0);

        // R10
        reset_b_chk: assert property (@(posedge cap_b_clk[g])
            rst |=> stash_b[g*LANE_W +: LANE_W] == '0);

        always_comb begin
            if (rst === 1'b0) begin
                // R8
                both_drive_chk: assert (!(a_drv[g] && b_drv[g]));
                if (en_n[g] === 1'b1) begin
                    // R3
                    isolate_chk: assert (!a_drv[g] && !b_drv[g] &&
                        a_out[g*LANE_W +: LANE_W] == '0 && b_out[g*LANE_W +: LANE_W] == '0);
                end
                if (en_n[g] === 1'b0 && dir[g] === 1'b0 && sel_a_src[g] === 1'b1) begin
                    // R6
                    stored_to_a_chk: assert (a_out[g*LANE_W +: LANE_W] == stash_b[g*LANE_W +: LANE_W]);
                end
                if (en_n[g] === 1'b0 && dir[g] === 1'b1 && sel_b_src[g] === 1'b1) begin
                    // R7
                    stored_to_b_chk: assert (b_out[g*LANE_W +: LANE_W] == stash_a[g*LANE_W +: LANE_W]);
                end
            end
        end
    end
endmodule

bind bus_xcvr_top xcvr_chk #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_chk (.*);

// File: tb/sim_bus_xcvr_top.sv
module sim_bus_xcvr_top;
    localparam int W = 8;
    localparam int L = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst;
    logic [L-1:0]     cap_a_clk, cap_b_clk, en_n, dir, sel_a_src, sel_b_src;
    logic [W*L-1:0]   a_in, b_in, a_out, b_out;
    logic [L-1:0]     a_drv, b_drv;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    bus_xcvr_top #(.LANE_W(W), .NUM_LANES(L)) u0 (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int l, input logic e, input logic d, input logic sa, input logic sb);
        en_n[l] = e; dir[l] = d; sel_a_src[l] = sa; sel_b_src[l] = sb;
        #1;
    endtask

    task automatic put(input int l, input logic [7:0] av, input logic [7:0] bv);
        a_in[l*W +: W] = av; b_in[l*W +: W] = bv;
        #1;
    endtask

    task automatic pulse_a(input int l);
        cap_a_clk[l] = 1'b1; #2; cap_a_clk[l] = 1'b0; #2;
    endtask

    task automatic pulse_b(input int l);
        cap_b_clk[l] = 1'b1; #2; cap_b_clk[l] = 1'b0; #2;
    endtask

    // read stored A via port B and stored B via port A, leaves lane enabled
    task automatic peek(input int l, output logic [7:0] ha, output logic [7:0] hb);
        cfg(l, 1'b0, 1'b1, 1'b0, 1'b1);
        ha = b_out[l*W +: W];
        cfg(l, 1'b0, 1'b0, 1'b1, 1'b0);
        hb = a_out[l*W +: W];
    endtask

    task automatic t_reset();
        logic [7:0] ha, hb;
        for (int l = 0; l < L; l++) begin
            put(l, 8'hA5, 8'h5A);
            peek(l, ha, hb);
            check("R10 reset A-held", ha, 8'h00);
            check("R10 reset B-held", hb, 8'h00);
        end
    endtask

    task automatic t_isolate();
        @(negedge clk);
        for (int l = 0; l < L; l++) begin
            for (int m = 0; m < 4; m++) begin
                cfg(l, 1'b1, m[0], m[1], ~m[0]);
                put(l, 8'h3C + 8'(m), 8'hC3 - 8'(m));
                check("R3 a_drv", {7'd0, a_drv[l]}, 8'd0);
                check("R3 b_drv", {7'd0, b_drv[l]}, 8'd0);
                check("R3 a_out", a_out[l*W +: W], 8'h00);
                check("R3 b_out", b_out[l*W +: W], 8'h00);
                check("R8 both", {7'd0, a_drv[l] & b_drv[l]}, 8'd0);
            end
        end
    endtask

    task automatic t_live();
        logic [7:0] pat [4] = '{8'h00, 8'hFF, 8'h96, 8'h01};
        @(negedge clk);
        for (int l = 0; l < L; l++) begin
            cfg(l, 1'b0, 1'b1, 1'b0, 1'b0);
            foreach (pat[k]) begin
                put(l, pat[k], ~pat[k]);
                check("R7 live a->b", b_out[l*W +: W], pat[k]);
                check("R5 a_out zero", a_out[l*W +: W], 8'h00);
                check("R5 drv", {6'd0, a_drv[l], b_drv[l]}, 8'h01);
            end
            cfg(l, 1'b0, 1'b0, 1'b0, 1'b0);
            foreach (pat[k]) begin
                put(l, ~pat[k], pat[k]);
                check("R6 live b->a", a_out[l*W +: W], pat[k]);
                check("R4 b_out zero", b_out[l*W +: W], 8'h00);
                check("R4 drv", {6'd0, a_drv[l], b_drv[l]}, 8'h02);
            end
        end
    endtask

    task automatic t_capture_disabled();
        logic [7:0] ha, hb;
        for (int l = 0; l < L; l++) begin
            cfg(l, 1'b1, 1'b0, 1'b0, 1'b0);
            put(l, 8'h5A, 8'hC3);
            pulse_a(l);
            pulse_b(l);
            put(l, 8'h11, 8'h22);
            peek(l, ha, hb);
            check("R1 capture while disabled", ha, 8'h5A);
            check("R2 capture while disabled", hb, 8'hC3);
            // enabled toward A while capturing A, toward B while capturing B
            cfg(l, 1'b0, 1'b0, 1'b1, 1'b0);
            put(l, 8'h77, 8'h88);
            pulse_a(l);
            cfg(l, 1'b0, 1'b1, 1'b0, 1'b1);
            pulse_b(l);
            put(l, 8'h00, 8'h00);
            peek(l, ha, hb);
            check("R1 capture opposite dir", ha, 8'h77);
            check("R2 capture opposite dir", hb, 8'h88);
        end
    endtask

    task automatic t_hold();
        logic [7:0] ha, hb;
        put(0, 8'h4B, 8'hB4);
        pulse_a(0);
        pulse_b(0);
        put(0, 8'hE1, 8'h1E);
        pulse_b(0);
        peek(0, ha, hb);
        check("R11 A-held kept across B clock", ha, 8'h4B);
        check("R2 B-held reload", hb, 8'h1E);
        put(0, 8'hF0, 8'h0F);
        peek(0, ha, hb);
        check("R11 A-held no edge", ha, 8'h4B);
        check("R11 B-held no edge", hb, 8'h1E);
    endtask

    task automatic t_independent();
        logic [7:0] ha, hb;
        put(1, 8'h69, 8'h96);
        pulse_a(1);
        pulse_b(1);
        cfg(1, 1'b0, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            put(0, 8'h10 + 8'(k), 8'h20 + 8'(k));
            cfg(0, 1'b0, k[0], k[0], ~k[0]);
            pulse_a(0);
            pulse_b(0);
            check("R9 lane1 b_out", b_out[W +: W], 8'h69);
            check("R9 lane1 a_out", a_out[W +: W], 8'h00);
        end
        peek(1, ha, hb);
        check("R9 lane1 A-held", ha, 8'h69);
        check("R9 lane1 B-held", hb, 8'h96);
        peek(0, ha, hb);
        check("R9 lane0 A-held", ha, 8'h12);
        check("R9 lane0 B-held", hb, 8'h22);
    endtask

    task automatic t_split_reset();
        logic [7:0] ha, hb;
        put(0, 8'hAA, 8'h55);
        pulse_a(0);
        pulse_b(0);
        rst = 1'b1;
        pulse_a(0);
        rst = 1'b0;
        #1;
        peek(0, ha, hb);
        check("R10 reset on A clock", ha, 8'h00);
        check("R10 B-held survives", hb, 8'h55);
        rst = 1'b1;
        pulse_b(0);
        rst = 1'b0;
        #1;
        peek(0, ha, hb);
        check("R10 reset on B clock", hb, 8'h00);
    endtask

    initial begin
        rst = 1'b1;
        cap_a_clk = '0; cap_b_clk = '0;
        en_n = '1; dir = '0; sel_a_src = '0; sel_b_src = '0;
        a_in = '0; b_in = '0;
        #3;
        for (int l = 0; l < L; l++) begin
            pulse_a(l);
            pulse_b(l);
        end
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_isolate();
        t_live();
        t_capture_disabled();
        t_hold();
        t_independent();
        t_split_reset();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule